// File: doc/BRIEF.md
# DDR SDRAM Bank and Power-State Tracker

This block models, on the device side, how a double-data-rate SDRAM reads its command pins. On every rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable, the two bank-address bits, a 13-bit address and the clock enable. From these it decodes the command and updates a record of which banks hold an open row and which row each one holds. It also tracks the low-power states and keeps the last values written to the two mode registers.

It flags, through a sticky bit, commands that the present bank state forbids. It raises a second sticky bit when clock enable is dropped while a read or write burst is still running. Auto-precharge is handled: a read or write with the auto-precharge address bit set closes its bank once the burst window ends. Self-refresh exit follows clock enable combinationally, so the reported power state leaves self refresh as soon as clock enable rises, before any clock edge. Data, strobe timing and analog behaviour are not modelled.

Top module: `ddr_bank_tracker`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears bank_open, every bank_row field, pwr_state, mode_reg, ext_mode_reg, illegal and cke_err to zero.
- R2: With clock enable high, an Active command ({cs_n,ras_n,cas_n,we_n} = 0011) to a closed bank sets bank_open[ba] after that edge and stores addr in bank_row[ba*13 +: 13].
- R3: A Precharge command (0010) with addr[10] low closes only bank ba; with addr[10] high it closes all four banks.
- R4: When cs_n is sampled high the command is a no-op whatever ras_n, cas_n and we_n are: bank state, mode registers and illegal do not change.
- R5: An Active to a bank that is already open, or a Read (0101) or Write (0100) to a closed bank, sets the sticky illegal flag and leaves bank_open and bank_row unchanged; illegal stays set until reset.
- R6: A mode-register command (0000) with every bank idle copies addr into mode_reg when ba = 0 and into ext_mode_reg when ba = 1; with ba = 2 or 3 neither register changes.
- R7: A mode-register command or an Auto Refresh (0001) issued while any bank is open sets illegal and changes no mode register.
- R8: A Read or Write with addr[10] high leaves its bank open for the next BURST_CYCLES-1 edges (default 3) and closes it at the BURST_CYCLES-th edge after the command.
- R9: pwr_state encodes 0 = active, 1 = precharge power-down, 2 = active power-down, 3 = self refresh. Clock enable sampled low in the active state enters 1 if no bank is open and 2 otherwise; commands sampled while powered down are ignored; clock enable sampled high leaves power-down for state 0.
- R10: An Auto Refresh command sampled with clock enable low and every bank idle enters self refresh (pwr_state = 3); pwr_state returns to 0 as soon as clock enable rises, without a clock edge.
- R11: Clock enable sampled low while a read or write burst window (BURST_CYCLES edges after the command) is still running sets the sticky cke_err flag; dropping it after the window has ended does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column/auto-precharge or op-code |
| bank_open | output | 4 | One bit per bank, set while a row is open |
| bank_row | output | 52 | Open row of bank b at bits b*13 +: 13 |
| pwr_state | output | 2 | Power state code |
| mode_reg | output | 13 | Last mode-register op-code |
| ext_mode_reg | output | 13 | Last extended mode-register op-code |
| illegal | output | 1 | Sticky illegal-command flag |
| cke_err | output | 1 | Sticky flag for clock enable dropped during a burst |

## Verification
On every cycle the assertions check that both error flags stay set once raised, that the reported power-down kind matches whether a bank is open, that self refresh is never shown with an open bank, that bank state is frozen while powered down, and that a deselected cycle changes no bank. Only the bench's scenarios can show the row captured by Active, the single-bank versus all-bank precharge choice, the mode-register selection by bank address, the exact edge at which auto-precharge closes a bank, the combinational self-refresh exit, and whether clock enable was dropped inside or after a burst window.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_PPD  = 2'd1,
        PWR_APD  = 2'd2,
        PWR_SREF = 2'd3
    } pwr_e;

endpackage

// File: rtl/ddr_trk_decode.sv
module ddr_trk_decode
    import ddr_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_trk_bank.sv
module ddr_trk_bank #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             is_open_o,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (close_i) begin
            slot_d.open = 1'b0;
        end else if (open_i) begin
            slot_d.open = 1'b1;
            slot_d.row  = row_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign is_open_o = slot_q.open;
    assign row_o     = slot_q.row;

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_trk_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int ROW_W        = 13,
    parameter int BURST_CYCLES = 4,
    parameter int AP_BIT       = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row,
    output logic [1:0]                 pwr_state,
    output logic [ROW_W-1:0]           mode_reg,
    output logic [ROW_W-1:0]           ext_mode_reg,
    output logic                       illegal,
    output logic                       cke_err
);

    localparam int BA_W  = $clog2(NUM_BANKS);
    localparam int CNT_W = $clog2(BURST_CYCLES + 1);

    typedef struct packed {
        pwr_e             pwr;
        logic             sref;
        logic [CNT_W-1:0] cnt;
        logic             ap_pend;
        logic [BA_W-1:0]  ap_bank;
        logic [ROW_W-1:0] mode;
        logic [ROW_W-1:0] emode;
        logic             illegal;
        logic             cke_err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    cmd_e cmd;

    logic [NUM_BANKS-1:0] open_w;
    logic [NUM_BANKS-1:0] set_v;
    logic [NUM_BANKS-1:0] clr_v;
    logic [NUM_BANKS-1:0] open_now;
    logic                 sref_hold;
    logic                 busy_ba;

    ddr_trk_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ddr_trk_bank #(.ROW_W(ROW_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .open_i    (set_v[b]),
            .close_i   (clr_v[b]),
            .row_i     (addr),
            .is_open_o (open_w[b]),
            .row_o     (bank_row[b*ROW_W +: ROW_W])
        );
    end

    // self refresh ends the moment clock enable rises
    assign sref_hold = ctl_q.sref & ~cke;

    always_comb begin
        ctl_d      = ctl_q;
        set_v      = '0;
        clr_v      = '0;
        open_now   = open_w;
        busy_ba    = 1'b0;
        ctl_d.sref = sref_hold;

        if (sref_hold) begin
            // all inputs ignored while in self refresh
        end else if (ctl_q.pwr != PWR_ON) begin
            if (cke) ctl_d.pwr = PWR_ON;
        end else if (!cke) begin
            if (ctl_q.cnt != '0) ctl_d.cke_err = 1'b1;
            ctl_d.cnt = '0;
            if (ctl_q.ap_pend) begin
                clr_v[ctl_q.ap_bank] = 1'b1;
                ctl_d.ap_pend        = 1'b0;
            end
            open_now = open_w & ~clr_v;
            if (cmd == CMD_REF && open_now == '0) begin
                ctl_d.sref = 1'b1;
            end else begin
                if (cmd == CMD_REF) ctl_d.illegal = 1'b1;
                ctl_d.pwr = (|open_now) ? PWR_APD : PWR_PPD;
            end
        end else begin
            if (ctl_q.cnt != '0) ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
            if (ctl_q.cnt == CNT_W'(1) && ctl_q.ap_pend) begin
                clr_v[ctl_q.ap_bank] = 1'b1;
                ctl_d.ap_pend        = 1'b0;
            end
            open_now = open_w & ~clr_v;
            busy_ba  = ctl_d.ap_pend && (ctl_d.ap_bank == ba);

            unique case (cmd)
                CMD_ACT: begin
                    if (open_now[ba]) ctl_d.illegal = 1'b1;
                    else              set_v[ba]     = 1'b1;
                end
                CMD_RD, CMD_WR: begin
                    if (!open_now[ba] || busy_ba) begin
                        ctl_d.illegal = 1'b1;
                    end else begin
                        if (ctl_d.ap_pend) clr_v[ctl_d.ap_bank] = 1'b1;
                        ctl_d.cnt     = CNT_W'(BURST_CYCLES);
                        ctl_d.ap_pend = addr[AP_BIT];
                        ctl_d.ap_bank = ba;
                    end
                end
                CMD_PRE: begin
                    if (addr[AP_BIT]) begin
                        clr_v         = '1;
                        ctl_d.ap_pend = 1'b0;
                    end else begin
                        clr_v[ba] = 1'b1;
                        if (busy_ba) ctl_d.ap_pend = 1'b0;
                    end
                end
                CMD_REF: begin
                    if (|open_now) ctl_d.illegal = 1'b1;
                end
                CMD_MRS: begin
                    if (|open_now)                ctl_d.illegal = 1'b1;
                    else if (ba == BA_W'(0))      ctl_d.mode    = addr;
                    else if (ba == BA_W'(1))      ctl_d.emode   = addr;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign bank_open    = open_w;
    assign pwr_state    = sref_hold ? PWR_SREF : ctl_q.pwr;
    assign mode_reg     = ctl_q.mode;
    assign ext_mode_reg = ctl_q.emode;
    assign illegal      = ctl_q.illegal;
    assign cke_err      = ctl_q.cke_err;

endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk #(
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 ap_pend,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [1:0]           pwr_state,
    input logic                 illegal,
    input logic                 cke_err
);

    assert_illegal_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        illegal |=> illegal);

    assert_cke_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        cke_err |=> cke_err);

    assert_sref_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd3) |-> (bank_open == '0));

    assert_ppd_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd1) |-> (bank_open == '0));

    assert_apd_open_R9: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd2) |-> (bank_open != '0));

    assert_pd_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        ((pwr_state == 2'd1 || pwr_state == 2'd2) && !cke) |=> $stable(bank_open));

    assert_cs_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (cs_n && cke && pwr_state == 2'd0 && !ap_pend) |=> $stable(bank_open));

endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cs_n      (cs_n),
    .ap_pend   (ctl_q.ap_pend),
    .bank_open (bank_open),
    .pwr_state (pwr_state),
    .illegal   (illegal),
    .cke_err   (cke_err)
);

// File: tb/ddr_bank_tracker_bench.sv
module ddr_bank_tracker_bench;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam int BURST = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [3:0]  bank_open;
    logic [51:0] bank_row;
    logic [1:0]  pwr_state;
    logic [12:0] mode_reg, ext_mode_reg;
    logic        illegal, cke_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ddr_bank_tracker u_ddr_bank_tracker (
        .clk, .rst, .cke, .cs_n, .ras_n, .cas_n, .we_n, .ba, .addr,
        .bank_open, .bank_row, .pwr_state, .mode_reg, .ext_mode_reg,
        .illegal, .cke_err
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic k, input logic [3:0] code, input logic [1:0] b,
                         input logic [12:0] a);
        @(negedge clk);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = code;
        ba = b;
        addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(1'b1, C_NOP, 2'd0, 13'd0);
        drive(1'b1, C_NOP, 2'd0, 13'd0);
        rst = 1'b0;
    endtask

    function automatic logic [12:0] row_of(input int b);
        return 13'(13'h101 * b + 13'd7);
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 bank_open", 64'(bank_open), 0);
        chk("R1 bank_row", 64'(bank_row), 0);
        chk("R1 pwr_state", 64'(pwr_state), 0);
        chk("R1 modes", 64'({mode_reg, ext_mode_reg}), 0);
        chk("R1 flags", 64'({illegal, cke_err}), 0);

        // R2: open each bank with a distinct row
        for (int b = 0; b < 4; b++) begin
            drive(1'b1, C_ACT, 2'(b), row_of(b));
            chk("R2 open bit", 64'(bank_open[b]), 1);
            chk("R2 row", 64'(bank_row[b*13 +: 13]), 64'(row_of(b)));
        end
        chk("R2 all open", 64'(bank_open), 64'hF);

        // R3: single-bank then all-bank precharge
        drive(1'b1, C_PRE, 2'd2, 13'h0000);
        chk("R3 single", 64'(bank_open), 64'hB);
        drive(1'b1, C_PRE, 2'd0, 13'h0400);
        chk("R3 all", 64'(bank_open), 64'h0);
        chk("R3 no illegal", 64'(illegal), 0);

        // R4: deselected cycles with every command pattern
        drive(1'b1, C_ACT, 2'd1, 13'h0055);
        for (int c = 0; c < 8; c++) begin
            drive(1'b1, {1'b1, 3'(c)}, 2'(c), 13'h1FFF);
            chk("R4 banks", 64'(bank_open), 64'h2);
            chk("R4 row", 64'(bank_row[13 +: 13]), 64'h55);
            chk("R4 modes", 64'({mode_reg, ext_mode_reg}), 0);
            chk("R4 illegal", 64'(illegal), 0);
        end

        // R5: activate to open bank
        drive(1'b1, C_ACT, 2'd1, 13'h0123);
        chk("R5 act illegal", 64'(illegal), 1);
        chk("R5 row kept", 64'(bank_row[13 +: 13]), 64'h55);
        drive(1'b1, C_NOP, 2'd0, 13'd0);
        chk("R5 sticky", 64'(illegal), 1);
        do_reset();
        drive(1'b1, C_RD, 2'd3, 13'h0000);
        chk("R5 rd closed", 64'(illegal), 1);
        chk("R5 rd banks", 64'(bank_open), 0);
        do_reset();
        drive(1'b1, C_WR, 2'd0, 13'h0400);
        chk("R5 wr closed", 64'(illegal), 1);

        // R6: mode register selection by bank address
        do_reset();
        drive(1'b1, C_MRS, 2'd0, 13'h0A5A);
        drive(1'b1, C_MRS, 2'd1, 13'h1234);
        chk("R6 mode", 64'(mode_reg), 64'h0A5A);
        chk("R6 ext", 64'(ext_mode_reg), 64'h1234);
        drive(1'b1, C_MRS, 2'd2, 13'h1FFF);
        drive(1'b1, C_MRS, 2'd3, 13'h0001);
        chk("R6 ba2/3 mode", 64'(mode_reg), 64'h0A5A);
        chk("R6 ba2/3 ext", 64'(ext_mode_reg), 64'h1234);
        chk("R6 no illegal", 64'(illegal), 0);
        drive(1'b1, C_REF, 2'd0, 13'd0);
        chk("R7 idle refresh", 64'(illegal), 0);

        // R7: mode register / refresh with open bank
        drive(1'b1, C_ACT, 2'd2, 13'h0009);
        drive(1'b1, C_MRS, 2'd0, 13'h0777);
        chk("R7 mrs illegal", 64'(illegal), 1);
        chk("R7 mode kept", 64'(mode_reg), 64'h0A5A);
        do_reset();
        drive(1'b1, C_ACT, 2'd0, 13'h0009);
        drive(1'b1, C_REF, 2'd0, 13'd0);
        chk("R7 ref illegal", 64'(illegal), 1);

        // R8: auto-precharge closes after the burst window
        do_reset();
        drive(1'b1, C_ACT, 2'd3, 13'h0042);
        drive(1'b1, C_ACT, 2'd1, 13'h0043);
        drive(1'b1, C_RD, 2'd3, 13'h0400);
        chk("R8 open at cmd", 64'(bank_open), 64'hA);
        for (int i = 1; i < BURST; i++) begin
            drive(1'b1, C_NOP, 2'd0, 13'd0);
            chk("R8 still open", 64'(bank_open), 64'hA);
        end
        drive(1'b1, C_NOP, 2'd0, 13'd0);
        chk("R8 closed", 64'(bank_open), 64'h2);
        drive(1'b1, C_WR, 2'd1, 13'h0000);
        for (int i = 0; i < BURST + 1; i++) drive(1'b1, C_NOP, 2'd0, 13'd0);
        chk("R8 no ap keeps open", 64'(bank_open), 64'h2);
        chk("R8 illegal", 64'(illegal), 0);

        // R9: power-down kinds
        do_reset();
        drive(1'b0, C_NOP, 2'd0, 13'd0);
        chk("R9 ppd", 64'(pwr_state), 1);
        drive(1'b0, C_ACT, 2'd1, 13'h0011);
        chk("R9 ppd ignores act", 64'(bank_open), 0);
        chk("R9 ppd hold", 64'(pwr_state), 1);
        drive(1'b1, C_NOP, 2'd0, 13'd0);
        chk("R9 ppd exit", 64'(pwr_state), 0);
        drive(1'b1, C_ACT, 2'd2, 13'h0011);
        drive(1'b0, C_NOP, 2'd0, 13'd0);
        chk("R9 apd", 64'(pwr_state), 2);
        drive(1'b0, C_PRE, 2'd0, 13'h0400);
        chk("R9 apd ignores pre", 64'(bank_open), 64'h4);
        drive(1'b1, C_NOP, 2'd0, 13'd0);
        chk("R9 apd exit", 64'(pwr_state), 0);

        // R10: self refresh entry and clockless exit
        do_reset();
        drive(1'b0, C_REF, 2'd0, 13'd0);
        chk("R10 enter", 64'(pwr_state), 3);
        drive(1'b0, C_ACT, 2'd0, 13'h0001);
        chk("R10 hold", 64'(pwr_state), 3);
        chk("R10 ignores act", 64'(bank_open), 0);
        @(negedge clk);
        cke = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        #1;
        chk("R10 async exit", 64'(pwr_state), 0);
        @(posedge clk);
        #1;
        chk("R10 after edge", 64'(pwr_state), 0);
        drive(1'b1, C_ACT, 2'd0, 13'h0003);
        drive(1'b0, C_REF, 2'd0, 13'd0);
        chk("R10 refused open", 64'(pwr_state), 2);
        chk("R10 refused illegal", 64'(illegal), 1);

        // R11: clock enable dropped inside / after a burst
        do_reset();
        drive(1'b1, C_ACT, 2'd0, 13'h0005);
        drive(1'b1, C_RD, 2'd0, 13'h0000);
        drive(1'b0, C_NOP, 2'd0, 13'd0);
        chk("R11 err inside", 64'(cke_err), 1);
        chk("R11 apd", 64'(pwr_state), 2);
        do_reset();
        drive(1'b1, C_ACT, 2'd0, 13'h0005);
        drive(1'b1, C_WR, 2'd0, 13'h0000);
        for (int i = 0; i < BURST; i++) drive(1'b1, C_NOP, 2'd0, 13'd0);
        drive(1'b0, C_NOP, 2'd0, 13'd0);
        chk("R11 no err after", 64'(cke_err), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule